// File: doc/BRIEF.md
# Phase-Indexed Fractional Delay Estimator

This block finds, once per control step, the delay that a repetitive controller must apply to look back exactly one fundamental period. It does so from the grid phase alone, without a frequency estimate. An outside phase tracker supplies one phase sample per step. The block keeps the most recent `DEPTH` phases in a ring. It looks for the pair of neighbouring stored samples whose phases enclose the current phase, allowing for the wrap at a full turn.

The age of the later sample of that pair gives the integer delay. The position of the current phase between the two stored phases gives two linear interpolation weights. The weight `weight1` applies to the sample at the integer delay, and `weight2` applies to the sample one step older. A signal delay line elsewhere combines these two taps into a fractional delay.

When the block is locked, each search starts near the previous step's match and looks at only a few entries. When it is not locked, it scans the whole history. The weights come from a bit-serial divider. A step therefore takes a number of cycles, and samples must arrive at least `DEPTH + 20` cycles apart.

Top module: `phase_delay_est`

## Requirements
- R1: Phases are unsigned `PHASE_W`-bit numbers, and 2^PHASE_W stands for one full turn. All phase differences are taken modulo 2^PHASE_W, so an enclosing pair that straddles the wrap is treated the same as one that does not.
- R2: After reset, `resultValid`, `delayInt`, `weight1` and `weight2` are zero. No result is produced for the first `DEPTH` samples after reset, because the history is still filling.
- R3: Each result reports `delayInt`. This is the number of steps between the current sample and the matched stored sample, and it lies in 1 to `DEPTH-1`.
- R4: A candidate sample c, together with the sample just before it (c-1), matches when three conditions hold. First, dB = phase(c) - phase(c-1) mod 2^PHASE_W is nonzero. Second, dB is below `GAP_LIMIT`. Third, dA = current phase - phase(c-1) mod 2^PHASE_W is at most dB.
- R5: `weight1` = floor(dA * 2^(PHASE_W-1) / dB) in unsigned Q1.(PHASE_W-1) format, where 2^(PHASE_W-1) means 1.0. `weight2` = 2^(PHASE_W-1) - `weight1`.
- R6: When the block is not locked, candidates are tried from age `DEPTH-1` down to age 1, and the first match is taken.
- R7: When the block is locked, the first candidate tried is the previous match, now one step older. If that age would reach `DEPTH`, the first candidate is age `DEPTH-1` instead. Candidates are then tried toward younger ages, at most `PROBES` of them and never below age 1, and the first match is taken.
- R8: A search with no match produces no result, leaves all outputs unchanged and clears the lock. A search with a match sets the lock.
- R9: `resultValid` is a one-cycle pulse, at most one per step. The outputs hold their values between results.
- R10: Every sample, whether or not it matched, enters the history exactly once. Each search therefore sees exactly the previous `DEPTH` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One-cycle strobe: a new phase sample is present |
| samplePhase | input | PHASE_W (16) | Phase sample, full turn = 2^PHASE_W |
| resultValid | output | 1 | One-cycle pulse: new delay and weights are available |
| delayInt | output | clog2(DEPTH) (9) | Integer delay in steps |
| weight1 | output | PHASE_W (16) | Weight of the tap at the integer delay, Q1.15 |
| weight2 | output | PHASE_W (16) | Weight of the tap one step older, Q1.15 |

## Verification
The first stimulus is a phase ramp whose step makes the period about 20 samples. This settles whether the match lands on the right age and whether the interpolation is exact on both sides of the wrap. The ramp slope is then changed twice. This shows whether the locked search follows a period that lengthens and one that shortens, within its window of a few entries.

Three further disturbances exercise the other paths:
- A single large phase jump forces a miss, and the following steps show the full-scan reacquisition.
- A repeated sample plants a zero-width pair in the history, which must be skipped.
- A stretch with phase steps wider than `GAP_LIMIT` makes every pair fail the gap test. The bench must then see no pulse, with the outputs held.

// File: rtl/phase_delay_pkg.sv
package phase_delay_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_DIV,
    ST_FIN,
    ST_STORE
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the incoming phase
    logic store;     // write latched phase into history
    logic loadDiv;   // load divider operands from the matching pair
    logic divStep;   // one divider iteration
    logic divFirst;  // iteration producing the integer bit
    logic publish;   // move quotient to the weight outputs
  } dpStrobe_t;

endpackage

// File: rtl/phase_delay_ctrl.sv
module phase_delay_ctrl
  import phase_delay_pkg::*;
#(
  parameter int DEPTH   = 409,
  parameter int PROBES  = 4,
  parameter int PHASE_W = 16,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          hit,
  output dpStrobe_t     strb,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] probePtr,
  output logic          resultValid,
  output logic [AW-1:0] delayInt
);

  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);
  localparam int            CW       = $clog2(PHASE_W);
  localparam logic [CW-1:0] DIV_LAST = CW'(PHASE_W - 1);

  ctrlState_t    state;
  logic [AW-1:0] prevKbar;
  logic [AW-1:0] probeCnt;
  logic [CW-1:0] divCnt;
  logic          filled;
  logic          locked;

  function automatic logic [AW-1:0] nextIdx(input logic [AW-1:0] x);
    return (x == LAST) ? '0 : x + 1'b1;
  endfunction

  logic [AW-1:0] probeLimit;
  logic          lastProbe;
  logic [AW:0]   ageWide;

  always_comb begin
    probeLimit = locked ? AW'(PROBES - 1) : AW'(DEPTH - 2);
    lastProbe  = (probeCnt == probeLimit) || (nextIdx(probePtr) == wrPtr);
    ageWide    = {1'b0, wrPtr} - {1'b0, probePtr};
    if (probePtr > wrPtr) ageWide = ageWide + (AW+1)'(DEPTH);
  end

  always_comb begin
    strb          = '0;
    strb.capture  = (state == ST_IDLE) && sampleValid;
    strb.store    = (state == ST_STORE);
    strb.loadDiv  = (state == ST_PROBE) && hit;
    strb.divStep  = (state == ST_DIV);
    strb.divFirst = (divCnt == '0);
    strb.publish  = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      wrPtr       <= '0;
      probePtr    <= '0;
      prevKbar    <= '0;
      probeCnt    <= '0;
      divCnt      <= '0;
      filled      <= 1'b0;
      locked      <= 1'b0;
      resultValid <= 1'b0;
      delayInt    <= '0;
    end else begin
      resultValid <= 1'b0;
      unique case (state)
        ST_IDLE: if (sampleValid) begin
          probeCnt <= '0;
          probePtr <= (locked && prevKbar != wrPtr) ? prevKbar : nextIdx(wrPtr);
          state    <= filled ? ST_PROBE : ST_STORE;
        end
        ST_PROBE: begin
          if (hit) begin
            divCnt <= '0;
            state  <= ST_DIV;
          end else if (lastProbe) begin
            locked <= 1'b0;
            state  <= ST_STORE;
          end else begin
            probePtr <= nextIdx(probePtr);
            probeCnt <= probeCnt + 1'b1;
          end
        end
        ST_DIV: begin
          divCnt <= divCnt + 1'b1;
          if (divCnt == DIV_LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          resultValid <= 1'b1;
          delayInt    <= ageWide[AW-1:0];
          locked      <= 1'b1;
          prevKbar    <= probePtr;
          state       <= ST_STORE;
        end
        ST_STORE: begin
          wrPtr <= nextIdx(wrPtr);
          if (wrPtr == LAST) filled <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !filled |-> !resultValid);

  // R3
  delay_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (delayInt != '0) && (delayInt <= AW'(DEPTH - 1)));

  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.store, strb.loadDiv, strb.divStep, strb.publish}));

endmodule

// File: rtl/phase_delay_dp.sv
module phase_delay_dp
  import phase_delay_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int DEPTH     = 409,
  parameter int GAP_LIMIT = 168,
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [PHASE_W-1:0] samplePhase,
  input  logic [AW-1:0]      wrPtr,
  input  logic [AW-1:0]      probePtr,
  output logic               hit,
  output logic [PHASE_W-1:0] weight1,
  output logic [PHASE_W-1:0] weight2
);

  localparam logic [AW-1:0]      LAST  = AW'(DEPTH - 1);
  localparam logic [PHASE_W:0]   GAP_L = (PHASE_W+1)'(GAP_LIMIT);
  localparam logic [PHASE_W-1:0] ONE   = PHASE_W'(1) << (PHASE_W - 1);

  logic [PHASE_W-1:0] hist [DEPTH];
  logic [PHASE_W-1:0] curPhase;
  logic [PHASE_W:0]   remR;
  logic [PHASE_W-1:0] divisorR;
  logic [PHASE_W-1:0] quot;

  logic [AW-1:0]      prevPtr;
  logic [PHASE_W-1:0] dA, dB;
  logic [PHASE_W:0]   cand;
  logic               ge;

  always_comb begin
    prevPtr = (probePtr == '0) ? LAST : probePtr - 1'b1;
    dB      = hist[probePtr] - hist[prevPtr];
    dA      = curPhase - hist[prevPtr];
    hit     = (dB != '0) && ({1'b0, dB} < GAP_L) && (dA <= dB);
    cand    = strb.divFirst ? remR : {remR[PHASE_W-1:0], 1'b0};
    ge      = cand >= {1'b0, divisorR};
  end

  always_ff @(posedge clk) begin
    if (strb.store) hist[wrPtr] <= curPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPhase <= '0;
      remR     <= '0;
      divisorR <= '0;
      quot     <= '0;
      weight1  <= '0;
      weight2  <= '0;
    end else begin
      if (strb.capture) curPhase <= samplePhase;
      if (strb.loadDiv) begin
        remR     <= {1'b0, dA};
        divisorR <= dB;
        quot     <= '0;
      end
      if (strb.divStep) begin
        remR <= ge ? cand - {1'b0, divisorR} : cand;
        quot <= {quot[PHASE_W-2:0], ge};
      end
      if (strb.publish) begin
        weight1 <= quot;
        weight2 <= ONE - quot;
      end
    end
  end

  // R5
  weight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    weight1 <= ONE);

  // R5
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.divStep |=> remR < {1'b0, divisorR});

endmodule

// File: rtl/phase_delay_est.sv
module phase_delay_est
  import phase_delay_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int DEPTH     = 409,
  parameter int PROBES    = 4,
  parameter int GAP_LIMIT = 168,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [PHASE_W-1:0] samplePhase,
  output logic               resultValid,
  output logic [AW-1:0]      delayInt,
  output logic [PHASE_W-1:0] weight1,
  output logic [PHASE_W-1:0] weight2
);

  dpStrobe_t     strb;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] probePtr;
  logic          hit;

  phase_delay_ctrl #(
    .DEPTH(DEPTH), .PROBES(PROBES), .PHASE_W(PHASE_W), .AW(AW)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .hit(hit),
    .strb(strb), .wrPtr(wrPtr), .probePtr(probePtr),
    .resultValid(resultValid), .delayInt(delayInt)
  );

  phase_delay_dp #(
    .PHASE_W(PHASE_W), .DEPTH(DEPTH), .GAP_LIMIT(GAP_LIMIT), .AW(AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .samplePhase(samplePhase),
    .wrPtr(wrPtr), .probePtr(probePtr), .hit(hit),
    .weight1(weight1), .weight2(weight2)
  );

endmodule

// File: tb/phase_delay_est_tb_top.sv
`timescale 1ns/1ps
module phase_delay_est_tb_top;

  localparam int DEPTH   = 24;
  localparam int PROBES  = 3;
  localparam int GAP     = 8000;
  localparam int AW      = $clog2(DEPTH);
  localparam int SPACING = 60;
  localparam int ONE     = 32768;

  logic          clk = 1'b0;
  logic          rstN;
  logic          sampleValid;
  logic [15:0]   samplePhase;
  logic          resultValid;
  logic [AW-1:0] delayInt;
  logic [15:0]   weight1, weight2;

  always #2 clk = ~clk;

  phase_delay_est #(.PHASE_W(16), .DEPTH(DEPTH), .PROBES(PROBES), .GAP_LIMIT(GAP)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .samplePhase(samplePhase),
    .resultValid(resultValid), .delayInt(delayInt), .weight1(weight1), .weight2(weight2)
  );

  int checks = 0, errors = 0;
  int hist[$];
  bit locked = 0;
  int prevAge = 0;
  int lastDelay = 0, lastW1 = 0, lastW2 = 0;
  int phaseAcc = 0;
  int pulses = 0;

  always @(negedge clk) if (rstN && resultValid) pulses++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int inc);
    int ph, a0, lim, expDelay, expW1, hb, hp, db, da;
    bit expHit, wrapCase;
    phaseAcc = (phaseAcc + inc) & 65535;
    ph = phaseAcc;
    expHit = 0; expDelay = 0; expW1 = 0; wrapCase = 0;
    if (hist.size() == DEPTH) begin
      if (locked) begin
        a0 = (prevAge + 1 > DEPTH - 1) ? DEPTH - 1 : prevAge + 1;
        lim = PROBES;
      end else begin
        a0 = DEPTH - 1;
        lim = DEPTH - 1;
      end
      for (int n = 0; n < lim && a0 - n >= 1 && !expHit; n++) begin
        hb = hist[DEPTH - (a0 - n)];
        hp = hist[DEPTH - (a0 - n) - 1];
        db = (hb - hp) & 65535;
        da = (ph - hp) & 65535;
        if (db != 0 && db < GAP && da <= db) begin
          expHit   = 1;
          expDelay = a0 - n;
          expW1    = int'((longint'(da) * ONE) / db);
          wrapCase = (hb < hp) || (ph < hp);
        end
      end
      locked = expHit;
      if (expHit) prevAge = expDelay;
    end
    hist.push_back(ph);
    if (hist.size() > DEPTH) void'(hist.pop_front());

    @(negedge clk);
    pulses = 0;
    sampleValid = 1'b1;
    samplePhase = ph[15:0];
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (SPACING) @(negedge clk);

    check(pulses == (expHit ? 1 : 0), "R2 R8 R9 result pulse count", pulses, expHit ? 1 : 0);
    if (expHit) begin
      check(int'(delayInt) == expDelay, "R3 R6 R7 R10 delay", int'(delayInt), expDelay);
      check(int'(weight1) == expW1, "R4 R5 weight1", int'(weight1), expW1);
      check(int'(weight2) == ONE - expW1, "R5 weight2", int'(weight2), ONE - expW1);
      if (wrapCase)
        check(int'(weight1) == expW1, "R1 weight1 across wrap", int'(weight1), expW1);
      lastDelay = expDelay; lastW1 = expW1; lastW2 = ONE - expW1;
    end else begin
      check(int'(delayInt) == lastDelay, "R8 R9 held delay", int'(delayInt), lastDelay);
      check(int'(weight1) == lastW1, "R8 R9 held weight1", int'(weight1), lastW1);
      check(int'(weight2) == lastW2, "R8 R9 held weight2", int'(weight2), lastW2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    sampleValid = 1'b0;
    samplePhase = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(resultValid == 1'b0, "R2 reset resultValid", int'(resultValid), 0);
    check(int'(delayInt) == 0, "R2 reset delay", int'(delayInt), 0);
    check(int'(weight1) == 0 && int'(weight2) == 0, "R2 reset weights",
          int'(weight1) + int'(weight2), 0);

    for (int i = 0; i < 64; i++) step(3277);   // fill then steady period near 20
    for (int i = 0; i < 40; i++) step(3000);   // longer period
    for (int i = 0; i < 40; i++) step(3500);   // shorter period
    step(20000);                               // phase jump forces a miss
    for (int i = 0; i < 30; i++) step(3277);   // full-scan reacquire
    step(0);                                   // repeated sample, zero-width pair
    for (int i = 0; i < 30; i++) step(3277);
    for (int i = 0; i < 12; i++) step(9000);   // gaps above the limit
    for (int i = 0; i < 40; i++) step(3277);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule